// File: doc/BRIEF.md
# Pointer-Addressed I2C Sensor Register Slave

This block is the serial front end of a temperature-sensing chip. It watches an open-drain SCL/SDA pair, which the system clock oversamples, and answers one 7-bit bus address. It holds four registers. Three are 16 bits wide: a live temperature value, a hysteresis limit and an upper limit. The fourth is an 8-bit configuration register. An internal pointer picks which register a transfer touches. The temperature arrives on a parallel input. The two limits and the configuration leave on parallel outputs, where the alarm logic of the chip reads them.

A write transfer always starts with a pointer byte after the address byte. Any bytes that follow are stored into the selected register. To read a different register, the master sends the pointer and then a repeated start. The master then addresses the block again with the read bit set. If the pointer already selects the wanted register, a read needs only the address. The length of a read or write follows the width of the register: one byte for configuration, two bytes for the others.

Top module: `i2cPtrSlave`

## Requirements
- R1: After reset, cfgOut is 0x00, hystOut is 0x4B00, limitOut is 0x5000 and sdaOe is 0, so SDA is released.
- R2: The block answers only the address byte whose upper four bits are 1001 and whose next three bits equal addrPins. Any other address gets no acknowledge, and the rest of that transfer changes no register.
- R3: The block acknowledges each accepted byte (a matching address, a pointer byte or a data byte) by holding sdaOe at 1 during the ninth SCL clock. It changes its SDA drive only while SCL is low.
- R4: Only the low two bits of the pointer are used: 00 temperature, 01 configuration, 10 hysteresis, 11 upper limit. The upper six bits have no effect.
- R5: A configuration write stores the first data byte after the pointer. Further data bytes in the same transfer are acknowledged and discarded.
- R6: A 16-bit write takes the more significant byte first. The register changes only when the second data byte is complete. A transfer that ends after one data byte leaves the register unchanged.
- R7: The temperature register is read-only. Data bytes written to it are acknowledged and do not change what is read back.
- R8: A read (address byte with bit 0 = 1) returns the register chosen by the pointer, most significant bit first: two bytes, upper byte first, for a 16-bit register, and one byte for configuration. The pointer keeps its value across transfers, so a read with no pointer byte reads the last selected register.
- R9: The low temperature byte is captured when the upper byte is loaded. A change on tempIn during a read cannot mix two samples.
- R10: After a read byte that the master does not acknowledge, the block releases SDA. It stays idle until the next start or stop.
- R11: A start or stop in the middle of a byte drops the partial byte. A start resumes address matching, and the transfer that follows behaves normally.
- R12: If the master acknowledges the last byte of a register, the block sends that register again from its first byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Level of the SCL line |
| sdaIn | input | 1 | Level of the SDA line |
| sdaOe | output | 1 | 1 pulls SDA low; 0 releases it |
| addrPins | input | 3 | Strapped low bits of the bus address |
| tempIn | input | 16 | Current temperature value |
| hystOut | output | 16 | Hysteresis limit register |
| limitOut | output | 16 | Upper limit register |
| cfgOut | output | 8 | Configuration register |

## Verification
The assertions assume that the master changes SDA only while SCL is low, except when it signals a start or a stop. They also assume that each SCL level lasts several system clocks, so the two-flop synchroniser never merges two edges. The bench master holds every SCL phase for at least five clocks. It moves SDA a quarter period after each falling SCL edge, and it forms the line as the wired-AND of its own drive and the block's pull-down. Under these conditions a change in the block's drive can only follow a falling SCL edge, and a stop can only arrive while the block has already released SDA.

// File: rtl/i2cPtrPkg.sv
package i2cPtrPkg;
  localparam int BYTE_W = 8;

  typedef struct packed {
    logic rxShift;   // sample SDA into the receive shifter
    logic ptrWr;     // received byte is the pointer
    logic wrFirst;   // received byte is the first data byte
    logic wrSecond;  // received byte is the second data byte
    logic txLoad;    // load the transmit shifter
    logic txLoadLo;  // qualifier of txLoad: lower byte wanted
    logic txShift;   // advance the transmit shifter
  } strobeT;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RX, ST_RXACK, ST_TX, ST_TXACK, ST_WAIT
  } ctrlStateT;
endpackage

// File: rtl/i2cPtrData.sv
module i2cPtrData
  import i2cPtrPkg::*;
#(
  parameter int REG_W = 16,
  parameter int CFG_W = 8,
  parameter logic [REG_W-1:0] HYST_RST = 16'h4B00,
  parameter logic [REG_W-1:0] LIM_RST  = 16'h5000,
  parameter logic [CFG_W-1:0] CFG_RST  = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobeT            strb,
  input  logic              sdaBit,
  input  logic [REG_W-1:0]  tempIn,
  output logic [BYTE_W-1:0] rxByte,
  output logic              txBit,
  output logic              wideReg,
  output logic [REG_W-1:0]  hystOut,
  output logic [REG_W-1:0]  limitOut,
  output logic [CFG_W-1:0]  cfgOut
);
  localparam int NUM_LIM = 2;

  logic [1:0]        ptr;
  logic [BYTE_W-1:0] rxSh, txSh, holdHi, snapLo, loadByte;
  logic [CFG_W-1:0]  cfgR;
  logic [REG_W-1:0]  limRegs [NUM_LIM];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptr    <= '0;
      rxSh   <= '0;
      holdHi <= '0;
      cfgR   <= CFG_RST;
    end else begin
      if (strb.rxShift) rxSh <= {rxSh[BYTE_W-2:0], sdaBit};
      if (strb.ptrWr) ptr <= rxSh[1:0];
      if (strb.wrFirst) begin
        if (ptr == 2'b01) cfgR <= rxSh[CFG_W-1:0];
        else holdHi <= rxSh;
      end
    end
  end

  // limit registers: pointer codes 2 (hysteresis) and 3 (upper limit)
  for (genvar g = 0; g < NUM_LIM; g++) begin : g_lim
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) limRegs[g] <= (g == 0) ? HYST_RST : LIM_RST;
      else if (strb.wrSecond && ptr == 2'(g + 2)) limRegs[g] <= {holdHi, rxSh};
    end
  end

  always_comb begin
    unique case (ptr)
      2'b00:   loadByte = strb.txLoadLo ? snapLo : tempIn[REG_W-1:BYTE_W];
      2'b01:   loadByte = cfgR;
      2'b10:   loadByte = strb.txLoadLo ? limRegs[0][BYTE_W-1:0] : limRegs[0][REG_W-1:BYTE_W];
      default: loadByte = strb.txLoadLo ? limRegs[1][BYTE_W-1:0] : limRegs[1][REG_W-1:BYTE_W];
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txSh   <= '1;
      snapLo <= '0;
    end else if (strb.txLoad) begin
      txSh <= loadByte;
      if (!strb.txLoadLo) snapLo <= tempIn[BYTE_W-1:0];
    end else if (strb.txShift) begin
      txSh <= {txSh[BYTE_W-2:0], 1'b1};
    end
  end

  assign rxByte   = rxSh;
  assign txBit    = txSh[BYTE_W-1];
  assign wideReg  = (ptr != 2'b01);
  assign hystOut  = limRegs[0];
  assign limitOut = limRegs[1];
  assign cfgOut   = cfgR;
endmodule

// File: rtl/i2cPtrCtrl.sv
module i2cPtrCtrl
  import i2cPtrPkg::*;
#(
  parameter logic [3:0] PREFIX = 4'b1001,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic [2:0]        addrPins,
  input  logic [BYTE_W-1:0] rxByte,
  input  logic              txBit,
  input  logic              wideReg,
  output strobeT            strb,
  output logic              sdaBit,
  output logic              sdaOe,
  output logic              sclLevel,
  output logic              startSeen,
  output logic              stopSeen
);
  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] LAST_RX = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] LAST_TX = CNT_W'(BYTE_W - 1);

  logic [SYNC_STAGES-1:0] sclSync, sdaSync;
  logic sclS, sdaS, sclPrev, sdaPrev, sclRise, sclFall;
  ctrlStateT state;
  logic [CNT_W-1:0] bitCnt;
  logic [2:0] byteCnt;
  logic isRead, txLo, ackOe, mAck, addrHit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclSync <= '1;
      sdaSync <= '1;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclSync <= {sclSync[SYNC_STAGES-2:0], sclIn};
      sdaSync <= {sdaSync[SYNC_STAGES-2:0], sdaIn};
      sclPrev <= sclS;
      sdaPrev <= sdaS;
    end
  end

  assign sclS      = sclSync[SYNC_STAGES-1];
  assign sdaS      = sdaSync[SYNC_STAGES-1];
  assign sclRise   = sclS & ~sclPrev;
  assign sclFall   = ~sclS & sclPrev;
  assign startSeen = sclS & sclPrev & sdaPrev & ~sdaS;
  assign stopSeen  = sclS & sclPrev & ~sdaPrev & sdaS;
  assign addrHit   = (rxByte[BYTE_W-1:1] == {PREFIX, addrPins});

  always_comb begin
    strb = '0;
    if (!startSeen && !stopSeen) begin
      unique case (state)
        ST_RX: begin
          strb.rxShift = sclRise;
          if (sclFall && bitCnt == LAST_RX) begin
            strb.ptrWr    = (byteCnt == 3'd1);
            strb.wrFirst  = (byteCnt == 3'd2);
            strb.wrSecond = (byteCnt == 3'd3);
          end
        end
        ST_RXACK: strb.txLoad = sclFall && byteCnt == 3'd0 && isRead;
        ST_TX:    strb.txShift = sclFall && bitCnt != LAST_TX;
        ST_TXACK: begin
          strb.txLoad   = sclFall && mAck;
          strb.txLoadLo = wideReg & ~txLo;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      bitCnt  <= '0;
      byteCnt <= '0;
      isRead  <= 1'b0;
      txLo    <= 1'b0;
      ackOe   <= 1'b0;
      mAck    <= 1'b0;
    end else if (startSeen) begin
      state   <= ST_RX;
      bitCnt  <= '0;
      byteCnt <= '0;
      ackOe   <= 1'b0;
    end else if (stopSeen) begin
      state <= ST_IDLE;
      ackOe <= 1'b0;
    end else begin
      unique case (state)
        ST_RX: begin
          if (sclRise) bitCnt <= bitCnt + 1'b1;
          if (sclFall && bitCnt == LAST_RX) begin
            if (byteCnt == 3'd0 && !addrHit) state <= ST_WAIT;
            else begin
              ackOe <= 1'b1;
              state <= ST_RXACK;
              if (byteCnt == 3'd0) isRead <= rxByte[0];
            end
          end
        end
        ST_RXACK: if (sclFall) begin
          ackOe  <= 1'b0;
          bitCnt <= '0;
          if (byteCnt == 3'd0 && isRead) begin
            state <= ST_TX;
            txLo  <= 1'b0;
          end else begin
            state <= ST_RX;
            if (byteCnt != 3'd4) byteCnt <= byteCnt + 1'b1;
          end
        end
        ST_TX: if (sclFall) begin
          if (bitCnt == LAST_TX) state <= ST_TXACK;
          else bitCnt <= bitCnt + 1'b1;
        end
        ST_TXACK: begin
          if (sclRise) mAck <= ~sdaS;
          if (sclFall) begin
            if (mAck) begin
              state  <= ST_TX;
              bitCnt <= '0;
              txLo   <= wideReg & ~txLo;
            end else state <= ST_WAIT;
          end
        end
        default: ;
      endcase
    end
  end

  assign sdaOe    = (state == ST_TX) ? ~txBit : ackOe;
  assign sdaBit   = sdaS;
  assign sclLevel = sclS;
endmodule

// File: rtl/i2cPtrSlave.sv
module i2cPtrSlave
  import i2cPtrPkg::*;
#(
  parameter logic [3:0] PREFIX = 4'b1001,
  parameter int SYNC_STAGES = 2,
  parameter int REG_W = 16,
  parameter int CFG_W = 8,
  parameter logic [REG_W-1:0] HYST_RST = 16'h4B00,
  parameter logic [REG_W-1:0] LIM_RST  = 16'h5000,
  parameter logic [CFG_W-1:0] CFG_RST  = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sclIn,
  input  logic             sdaIn,
  output logic             sdaOe,
  input  logic [2:0]       addrPins,
  input  logic [REG_W-1:0] tempIn,
  output logic [REG_W-1:0] hystOut,
  output logic [REG_W-1:0] limitOut,
  output logic [CFG_W-1:0] cfgOut
);
  strobeT strb;
  logic [BYTE_W-1:0] rxByte;
  logic txBit, wideReg, sdaBit, sclLevel, startSeen, stopSeen;

  i2cPtrCtrl #(.PREFIX(PREFIX), .SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn), .addrPins(addrPins),
    .rxByte(rxByte), .txBit(txBit), .wideReg(wideReg), .strb(strb),
    .sdaBit(sdaBit), .sdaOe(sdaOe), .sclLevel(sclLevel),
    .startSeen(startSeen), .stopSeen(stopSeen)
  );

  i2cPtrData #(.REG_W(REG_W), .CFG_W(CFG_W), .HYST_RST(HYST_RST),
               .LIM_RST(LIM_RST), .CFG_RST(CFG_RST)) u_data (
    .clk(clk), .rstN(rstN), .strb(strb), .sdaBit(sdaBit), .tempIn(tempIn),
    .rxByte(rxByte), .txBit(txBit), .wideReg(wideReg),
    .hystOut(hystOut), .limitOut(limitOut), .cfgOut(cfgOut)
  );
endmodule

// File: rtl/i2cPtrChk.sv
module i2cPtrChk
  import i2cPtrPkg::*;
#(
  parameter int REG_W = 16,
  parameter int CFG_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             sclLevel,
  input logic             stopSeen,
  input logic             sdaOe,
  input strobeT           strb,
  input logic [REG_W-1:0] hystOut,
  input logic [REG_W-1:0] limitOut,
  input logic [CFG_W-1:0] cfgOut
);
  // R10
  stop_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    stopSeen |=> !sdaOe);

  // R3
  sda_edge_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaOe) |-> !sclLevel);

  // R5
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.wrFirst |=> $stable(cfgOut));

  // R6
  limit_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.wrSecond |=> ($stable(limitOut) && $stable(hystOut)));

  // R3
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.rxShift, strb.ptrWr, strb.wrFirst, strb.wrSecond,
              strb.txLoad, strb.txShift}));
endmodule

bind i2cPtrSlave i2cPtrChk #(.REG_W(REG_W), .CFG_W(CFG_W)) u_chk (
  .clk(clk), .rstN(rstN), .sclLevel(sclLevel), .stopSeen(stopSeen),
  .sdaOe(sdaOe), .strb(strb), .hystOut(hystOut), .limitOut(limitOut),
  .cfgOut(cfgOut)
);

// File: tb/sim_i2cPtrSlave.sv
module sim_i2cPtrSlave;
  localparam int Q = 5;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rstN = 1'b0;
  logic sclM = 1'b1, sdaM = 1'b1;
  logic [2:0] addrPins = 3'b101;
  logic [15:0] tempIn = 16'h0C40;
  logic sdaOe;
  logic [15:0] hystOut, limitOut;
  logic [7:0] cfgOut;
  wire sdaLine = sdaM & ~sdaOe;

  i2cPtrSlave u0 (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaLine), .sdaOe(sdaOe),
    .addrPins(addrPins), .tempIn(tempIn), .hystOut(hystOut),
    .limitOut(limitOut), .cfgOut(cfgOut)
  );

  int checks = 0, fails = 0;
  logic [7:0] mCfg = 8'h00;
  logic [15:0] mHyst = 16'h4B00, mLim = 16'h5000;
  bit settle = 1'b1;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // reference register state compared on every clock outside write windows
  always @(negedge clk) begin
    if (rstN && !settle) begin
      chk("R2/R5/R6 cfg", {24'd0, cfgOut}, {24'd0, mCfg});
      chk("R6 hyst", {16'd0, hystOut}, {16'd0, mHyst});
      chk("R6 limit", {16'd0, limitOut}, {16'd0, mLim});
    end
  end

  task automatic q(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sendBit(input logic b);
    sdaM = b; q(Q); sclM = 1'b1; q(2*Q); sclM = 1'b0; q(Q);
  endtask

  task automatic recvBit(output logic b);
    sdaM = 1'b1; q(Q); sclM = 1'b1; q(Q); b = sdaLine; q(Q); sclM = 1'b0; q(Q);
  endtask

  task automatic startCond();
    sdaM = 1'b1; q(Q); sclM = 1'b1; q(2*Q); sdaM = 1'b0; q(2*Q); sclM = 1'b0; q(Q);
  endtask

  task automatic stopCond();
    sdaM = 1'b0; q(Q); sclM = 1'b1; q(2*Q); sdaM = 1'b1; q(2*Q);
  endtask

  task automatic sendByte(input logic [7:0] b, output logic ack);
    logic bit9;
    for (int i = 7; i >= 0; i--) sendBit(b[i]);
    recvBit(bit9);
    ack = ~bit9;
  endtask

  task automatic readByte(input logic giveAck, output logic [7:0] d);
    for (int i = 7; i >= 0; i--) recvBit(d[i]);
    sendBit(~giveAck);
  endtask

  function automatic logic [7:0] addrByte(input logic rd);
    return {4'b1001, addrPins, rd};
  endfunction

  // pointer write followed by n data bytes; leaves settle set for the caller
  task automatic wr(input logic [7:0] ptr, input int n,
                    input logic [7:0] b0, input logic [7:0] b1, input logic [7:0] b2,
                    input string tag);
    logic ack;
    logic [7:0] data [3];
    data[0] = b0; data[1] = b1; data[2] = b2;
    settle = 1'b1;
    startCond();
    sendByte(addrByte(1'b0), ack); chk("R3 address ack", {31'd0, ack}, 32'd1);
    sendByte(ptr, ack);            chk("R3 pointer ack", {31'd0, ack}, 32'd1);
    for (int i = 0; i < n; i++) begin
      sendByte(data[i], ack);
      chk(tag, {31'd0, ack}, 32'd1);
    end
    stopCond();
  endtask

  task automatic rd(input bit setPtr, input logic [7:0] ptr, input int n,
                    input logic [15:0] tempAfter,
                    output logic [7:0] r0, output logic [7:0] r1);
    logic ack;
    r1 = 8'h00;
    startCond();
    if (setPtr) begin
      sendByte(addrByte(1'b0), ack); chk("R3 address ack", {31'd0, ack}, 32'd1);
      sendByte(ptr, ack);            chk("R3 pointer ack", {31'd0, ack}, 32'd1);
      startCond();
    end
    sendByte(addrByte(1'b1), ack); chk("R8 read address ack", {31'd0, ack}, 32'd1);
    readByte(n > 1, r0);
    tempIn = tempAfter;
    if (n > 1) readByte(1'b0, r1);
    stopCond();
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired, actual running expected done");
    finishRun();
  end

  initial begin
    logic ack, bitv;
    logic [7:0] r0, r1;
    q(5);
    chk("R1 sdaOe in reset", {31'd0, sdaOe}, 32'd0);
    rstN = 1'b1;
    q(5);
    chk("R1 cfg reset", {24'd0, cfgOut}, 32'h00);
    chk("R1 hyst reset", {16'd0, hystOut}, 32'h4B00);
    chk("R1 limit reset", {16'd0, limitOut}, 32'h5000);
    chk("R1 sda released", {31'd0, sdaOe}, 32'd0);
    settle = 1'b0;

    // R2: foreign address is ignored
    startCond();
    sendByte({4'b1001, 3'b000, 1'b0}, ack); chk("R2 foreign address", {31'd0, ack}, 32'd0);
    sendByte(8'h01, ack);                   chk("R2 pointer after miss", {31'd0, ack}, 32'd0);
    sendByte(8'hAA, ack);                   chk("R2 data after miss", {31'd0, ack}, 32'd0);
    stopCond();
    chk("R2 cfg untouched", {24'd0, cfgOut}, 32'h00);

    // R5: configuration write, extra byte discarded
    wr(8'h01, 2, 8'h5A, 8'h33, 8'h00, "R5 cfg data ack");
    mCfg = 8'h5A; q(2); settle = 1'b0;
    chk("R5 cfg written", {24'd0, cfgOut}, 32'h5A);

    // R6: 16-bit writes
    wr(8'h03, 2, 8'h55, 8'h80, 8'h00, "R6 limit data ack");
    mLim = 16'h5580; q(2); settle = 1'b0;
    chk("R6 limit written", {16'd0, limitOut}, 32'h5580);
    wr(8'h02, 2, 8'h12, 8'h34, 8'h00, "R6 hyst data ack");
    mHyst = 16'h1234; q(2); settle = 1'b0;
    chk("R6 hyst written", {16'd0, hystOut}, 32'h1234);
    wr(8'h03, 1, 8'h77, 8'h00, 8'h00, "R6 single byte ack");
    q(2); settle = 1'b0;
    chk("R6 partial write ignored", {16'd0, limitOut}, 32'h5580);

    // R7: temperature is read-only
    wr(8'h00, 2, 8'hDE, 8'hAD, 8'h00, "R7 temp write ack");
    q(2); settle = 1'b0;
    rd(1'b0, 8'h00, 2, tempIn, r0, r1);
    chk("R7 temp readback", {16'd0, r0, r1}, {16'd0, tempIn});

    // R4: upper pointer bits ignored
    wr(8'hF1, 1, 8'hC3, 8'h00, 8'h00, "R4 cfg via F1 ack");
    mCfg = 8'hC3; q(2); settle = 1'b0;
    chk("R4 cfg via pointer F1", {24'd0, cfgOut}, 32'hC3);

    // R8: reads with pointer set and with preset pointer
    rd(1'b1, 8'h03, 2, tempIn, r0, r1);
    chk("R8 limit read", {16'd0, r0, r1}, 32'h5580);
    rd(1'b0, 8'h00, 2, tempIn, r0, r1);
    chk("R8 preset pointer read", {16'd0, r0, r1}, 32'h5580);
    rd(1'b1, 8'h01, 1, tempIn, r0, r1);
    chk("R8 cfg one byte", {24'd0, r0}, 32'hC3);
    rd(1'b1, 8'hFE, 2, tempIn, r0, r1);
    chk("R8 hyst read via FE", {16'd0, r0, r1}, 32'h1234);

    // R9: temperature snapshot
    tempIn = 16'h1A80;
    rd(1'b1, 8'h00, 2, 16'h2BF0, r0, r1);
    chk("R9 coherent temp", {16'd0, r0, r1}, 32'h1A80);
    rd(1'b0, 8'h00, 2, 16'h2BF0, r0, r1);
    chk("R9 new temp", {16'd0, r0, r1}, 32'h2BF0);

    // R12: acknowledged last byte wraps
    rd(1'b1, 8'h01, 2, tempIn, r0, r1);
    chk("R12 cfg repeated", {16'd0, r0, r1}, 32'hC3C3);

    // R10: master NACK releases SDA
    startCond();
    sendByte(addrByte(1'b1), ack);
    readByte(1'b0, r0);
    chk("R10 released after nack", {31'd0, sdaOe}, 32'd0);
    recvBit(bitv);
    chk("R10 line stays high", {31'd0, bitv}, 32'd1);
    stopCond();

    // R11: start and stop in the middle of a byte
    startCond();
    sendBit(1'b1); sendBit(1'b0); sendBit(1'b0); sendBit(1'b1);
    wr(8'h01, 1, 8'h9E, 8'h00, 8'h00, "R11 write after abort ack");
    mCfg = 8'h9E; q(2); settle = 1'b0;
    chk("R11 cfg after abort", {24'd0, cfgOut}, 32'h9E);
    startCond();
    sendBit(1'b1); sendBit(1'b0); sendBit(1'b0);
    stopCond();
    rd(1'b0, 8'h00, 1, tempIn, r0, r1);
    chk("R11 read after stop abort", {24'd0, r0}, 32'h9E);

    q(20);
    finishRun();
  end
endmodule